// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the raster timing for one display output. It runs on a pixel clock supplied from outside. It keeps a horizontal pixel counter and a vertical line counter. From them it derives a horizontal sync pulse, a vertical sync pulse and a data-enable strobe. Each sync pulse can be inverted. Software sets the geometry and the control bits through a small register bank on a single-cycle write bus with a combinational read path.

Most geometry values are stored one below their real value. This covers totals, display ends and sync start positions. Sync widths are stored as plain counts. The control word applies timing enable, the polarity bits and the clock-phase bit at once. The plane-enable bit is held in a shadow copy while the raster runs. That copy moves to the live copy only on the first pixel of the vertical sync pulse, so a picture is never cut off partway through a frame. Readback of the control word shows the live copy. Software that polls for its new value therefore sees the old plane state until that point.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset both counters are 0, hsync, vsync, de and pclk_invert are 0, and every register reads 0.
- R2: Address 1 (horizontal total), 2 (horizontal sync), 3 (vertical total) and 4 (vertical sync) each hold two 12-bit fields: the upper field in bits 27:16 and the lower field in bits 11:0. A readback returns the written field bits with all other bits zero. The fields are total-1 and display-end-1 at addresses 1 and 3, and sync-width and sync-start-1 at addresses 2 and 4.
- R3: In the control word at address 0, bit 0 is timing enable. While it is 0 both counters hold at 0, de is 0, and each sync output sits at its inactive level, which equals its polarity bit.
- R4: While timing is enabled, the horizontal counter advances by 1 on every clock and wraps to 0 after reaching total-1. The vertical counter advances only on that wrap and wraps to 0 after total-1.
- R5: de is 1 exactly when timing is enabled, the live plane bit (control bit 1) is 1, hcount is at most the horizontal display-end-1 field, and vcount is at most the vertical display-end-1 field.
- R6: The raw hsync is active for hcount from sync-start-1 up to and including sync-start-1 plus width minus 1. A width of 0 gives no pulse.
- R7: The raw vsync follows the same rule as R6, using vcount and the vertical sync register.
- R8: Control bit 2 inverts hsync and bit 3 inverts vsync. Both take effect on the clock that writes them.
- R9: While timing is enabled, a plane-enable write reaches the live copy only on the clock whose counts are hcount 0 and vcount equal to vertical sync-start-1. Until then, de and the readback of bit 1 keep the old value.
- R10: While timing is disabled, a plane-enable write reaches the live copy on the clock that writes it.
- R11: Control readback bit 8 is a read-only status that is 1 while the raw vsync is active and timing is enabled. Control bits 31:9 and 7:5 always read 0, whatever was written to them.
- R12: Control bit 4 drives pclk_invert and takes effect on the clock that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one clock per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hcount | output | 12 | Horizontal pixel count |
| vcount | output | 12 | Vertical line count |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable, active pixel |
| pclk_invert | output | 1 | Request to invert the output pixel clock phase |

## Verification
A wrong counter state shows on the hcount and vcount outputs on the very next clock. A wrong wrap point shows as a frame of the wrong length within one line or one frame. A scoreboard therefore compares counts, syncs and de every cycle across two full frames and across a frame with inverted polarity. A wrong shadow state for the plane bit is more hidden: it shows only as control readback or de differing around the vertical sync line. It is probed on the clocks just before and just after the load point, and on the first line of the following frame.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;
  // control word bit positions
  localparam int unsigned CTRL_TEN   = 0;
  localparam int unsigned CTRL_PLANE = 1;
  localparam int unsigned CTRL_HINV  = 2;
  localparam int unsigned CTRL_VINV  = 3;
  localparam int unsigned CTRL_CPH   = 4;
  localparam int unsigned CTRL_VSTAT = 8;
  // upper field position in geometry registers
  localparam int unsigned HI_LSB     = 16;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_HTOT = 3'd1,
    A_HSYN = 3'd2,
    A_VTOT = 3'd3,
    A_VSYN = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic cph;
    logic vinv;
    logic hinv;
    logic plane;
    logic ten;
  } ctrl_t;
endpackage

// File: rtl/dtg_rst_sync.sv
`timescale 1ns/1ps
module dtg_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= '0;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/dtg_axis.sv
`timescale 1ns/1ps
module dtg_axis #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] tot_m1,
  input  logic [CW-1:0] dend_m1,
  input  logic [CW-1:0] sst_m1,
  input  logic [CW-1:0] swid,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          in_disp,
  output logic          in_sync
);
  localparam int unsigned EW = CW + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [EW-1:0] sync_lo, sync_hi, cnt_ext;

  assign wrap   = run && step && (cnt_q == tot_m1);
  assign cnt_en = !run || step;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_ext = {1'b0, cnt_q};
  assign sync_lo = {1'b0, sst_m1};
  assign sync_hi = {1'b0, sst_m1} + {1'b0, swid};

  assign cnt     = cnt_q;
  assign in_disp = (cnt_q <= dend_m1);
  assign in_sync = (cnt_ext >= sync_lo) && (cnt_ext < sync_hi);

  // R3: a stopped axis is parked at zero
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  // R4: wrap returns to zero
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
  // R4: ordinary step adds one
  assert_step_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !wrap) |=> (cnt == $past(cnt) + 1'b1));
  // R4: no step, no motion
  assert_hold_nostep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(cnt));
endmodule

// File: rtl/dtg_regs.sv
`timescale 1ns/1ps
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 3,
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          load_plane,
  input  logic          vstat,
  output logic [DW-1:0] rdata,
  output ctrl_t         ctrl,
  output logic [HW-1:0] h_tot_m1,
  output logic [HW-1:0] h_dend_m1,
  output logic [HW-1:0] h_sst_m1,
  output logic [HW-1:0] h_swid,
  output logic [VW-1:0] v_tot_m1,
  output logic [VW-1:0] v_dend_m1,
  output logic [VW-1:0] v_sst_m1,
  output logic [VW-1:0] v_swid
);
  logic wr_ctrl, wr_htot, wr_hsyn, wr_vtot, wr_vsyn;
  logic unused_wdata;

  assign wr_ctrl = wr && (addr == AW'(A_CTRL));
  assign wr_htot = wr && (addr == AW'(A_HTOT));
  assign wr_hsyn = wr && (addr == AW'(A_HSYN));
  assign wr_vtot = wr && (addr == AW'(A_VTOT));
  assign wr_vsyn = wr && (addr == AW'(A_VSYN));
  assign unused_wdata = ^wdata;

  // geometry registers
  logic [HW-1:0] htot_q, hdend_q, hsst_q, hswid_q;
  logic [VW-1:0] vtot_q, vdend_q, vsst_q, vswid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htot_q  <= '0;
      hdend_q <= '0;
    end else if (wr_htot) begin
      htot_q  <= wdata[HI_LSB +: HW];
      hdend_q <= wdata[0 +: HW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hswid_q <= '0;
      hsst_q  <= '0;
    end else if (wr_hsyn) begin
      hswid_q <= wdata[HI_LSB +: HW];
      hsst_q  <= wdata[0 +: HW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtot_q  <= '0;
      vdend_q <= '0;
    end else if (wr_vtot) begin
      vtot_q  <= wdata[HI_LSB +: VW];
      vdend_q <= wdata[0 +: VW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vswid_q <= '0;
      vsst_q  <= '0;
    end else if (wr_vsyn) begin
      vswid_q <= wdata[HI_LSB +: VW];
      vsst_q  <= wdata[0 +: VW];
    end
  end

  // control: immediate bits, shadowed plane bit
  ctrl_t ctrl_q, ctrl_d;
  logic  shd_q, shd_d;
  logic  ctrl_en;

  always_comb begin
    shd_d  = shd_q;
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      shd_d       = wdata[CTRL_PLANE];
      ctrl_d.ten  = wdata[CTRL_TEN];
      ctrl_d.hinv = wdata[CTRL_HINV];
      ctrl_d.vinv = wdata[CTRL_VINV];
      ctrl_d.cph  = wdata[CTRL_CPH];
    end
    if (load_plane) ctrl_d.plane = shd_d;
  end

  assign ctrl_en = wr_ctrl || load_plane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      shd_q  <= 1'b0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
      shd_q  <= shd_d;
    end
  end

  // readback
  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_CTRL): begin
        rdata[CTRL_TEN]   = ctrl_q.ten;
        rdata[CTRL_PLANE] = ctrl_q.plane;
        rdata[CTRL_HINV]  = ctrl_q.hinv;
        rdata[CTRL_VINV]  = ctrl_q.vinv;
        rdata[CTRL_CPH]   = ctrl_q.cph;
        rdata[CTRL_VSTAT] = vstat;
      end
      AW'(A_HTOT): begin
        rdata[HI_LSB +: HW] = htot_q;
        rdata[0 +: HW]      = hdend_q;
      end
      AW'(A_HSYN): begin
        rdata[HI_LSB +: HW] = hswid_q;
        rdata[0 +: HW]      = hsst_q;
      end
      AW'(A_VTOT): begin
        rdata[HI_LSB +: VW] = vtot_q;
        rdata[0 +: VW]      = vdend_q;
      end
      AW'(A_VSYN): begin
        rdata[HI_LSB +: VW] = vswid_q;
        rdata[0 +: VW]      = vsst_q;
      end
      default: rdata = '0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign h_tot_m1  = htot_q;
  assign h_dend_m1 = hdend_q;
  assign h_sst_m1  = hsst_q;
  assign h_swid    = hswid_q;
  assign v_tot_m1  = vtot_q;
  assign v_dend_m1 = vdend_q;
  assign v_sst_m1  = vsst_q;
  assign v_swid    = vswid_q;

  // R9: live plane bit only moves on a load clock
  assert_plane_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_plane |=> $stable(ctrl.plane));
  // R11: unused control bits read as zero
  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(A_CTRL)) |-> (rdata[7:5] == 3'b000 && rdata[DW-1:9] == '0));
endmodule

// File: rtl/disp_timing_gen.sv
`timescale 1ns/1ps
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 3,
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclk_invert
);
  logic          rst_n_s;
  ctrl_t         ctrl;
  logic [HW-1:0] h_tot_m1, h_dend_m1, h_sst_m1, h_swid;
  logic [VW-1:0] v_tot_m1, v_dend_m1, v_sst_m1, v_swid;
  logic          h_wrap, h_disp, h_sync;
  logic          v_wrap, v_disp, v_sync;
  logic          load_plane, vstat;
  logic          unused_vwrap;

  dtg_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  // plane copy: every clock while stopped, else first pixel of vsync pulse
  assign load_plane = !ctrl.ten ||
                      ((hcount == '0) && (vcount == v_sst_m1) && (v_swid != '0));
  assign vstat      = ctrl.ten && v_sync;

  dtg_regs #(.DW(DW), .AW(AW), .HW(HW), .VW(VW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr         (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .load_plane (load_plane),
    .vstat      (vstat),
    .rdata      (bus_rdata),
    .ctrl       (ctrl),
    .h_tot_m1   (h_tot_m1),
    .h_dend_m1  (h_dend_m1),
    .h_sst_m1   (h_sst_m1),
    .h_swid     (h_swid),
    .v_tot_m1   (v_tot_m1),
    .v_dend_m1  (v_dend_m1),
    .v_sst_m1   (v_sst_m1),
    .v_swid     (v_swid)
  );

  dtg_axis #(.CW(HW)) u_haxis (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run     (ctrl.ten),
    .step    (1'b1),
    .tot_m1  (h_tot_m1),
    .dend_m1 (h_dend_m1),
    .sst_m1  (h_sst_m1),
    .swid    (h_swid),
    .cnt     (hcount),
    .wrap    (h_wrap),
    .in_disp (h_disp),
    .in_sync (h_sync)
  );

  dtg_axis #(.CW(VW)) u_vaxis (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run     (ctrl.ten),
    .step    (h_wrap),
    .tot_m1  (v_tot_m1),
    .dend_m1 (v_dend_m1),
    .sst_m1  (v_sst_m1),
    .swid    (v_swid),
    .cnt     (vcount),
    .wrap    (v_wrap),
    .in_disp (v_disp),
    .in_sync (v_sync)
  );

  assign unused_vwrap = v_wrap;

  assign de          = ctrl.ten && ctrl.plane && h_disp && v_disp;
  assign hsync       = (ctrl.ten && h_sync) ^ ctrl.hinv;
  assign vsync       = (ctrl.ten && v_sync) ^ ctrl.vinv;
  assign pclk_invert = ctrl.cph;

  // R3: stopped raster parks syncs at their inactive level
  assert_sync_idle_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctrl.ten |-> (hsync == ctrl.hinv && vsync == ctrl.vinv && !de));
  // R5: data enable never outside the programmed active window
  assert_de_window_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    de |-> (hcount <= h_dend_m1 && vcount <= v_dend_m1));
  // R4: the line counter never moves in the middle of a line while running
  assert_vline_step_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl.ten && hcount != h_tot_m1) |=> $stable(vcount));
endmodule

// File: tb/test_disp_timing_gen.sv
`timescale 1ns/1ps
module test_disp_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [11:0] hcount, vcount;
  logic        hsync, vsync, de, pclk_invert;

  always #2.5 clk = ~clk;

  disp_timing_gen i_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hcount(hcount),
    .vcount(vcount), .hsync(hsync), .vsync(vsync), .de(de),
    .pclk_invert(pclk_invert)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int hc;
    int vc;
    bit hs;
    bit vs;
    bit de;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // geometry used by the bench (real values, not minus one):
  // h total 10, display 6, sync start 8, width 2
  // v total 6, display 4, sync start 5, height 1
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic start_run(input logic [31:0] c);
    wr(3'd0, c & 32'hFFFF_FFFE);
    wr(3'd0, c);
  endtask

  task automatic push_run(input int n, input bit hi, input bit vi, input bit pl);
    int h = 0;
    int v = 0;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      if (h == 9) begin
        h = 0;
        v = (v == 5) ? 0 : v + 1;
      end else begin
        h = h + 1;
      end
      e.hc = h;
      e.vc = v;
      e.hs = (h >= 7 && h < 9) ^ hi;
      e.vs = (v == 4) ^ vi;
      e.de = pl && (h <= 5) && (v <= 3);
      sb_q.push_back(e);
    end
  endtask

  task automatic wait_pos(input int h, input int v);
    @(negedge clk);
    while (!(hcount == 12'(h) && vcount == 12'(v))) @(negedge clk);
  endtask

  // scoreboard monitor: one expected item per clock, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        longint act, expv;
        e = sb_q.pop_front();
        act  = {32'(hcount), 16'(vcount), 8'(hsync), 4'(vsync), 4'(de)};
        expv = {32'(e.hc), 16'(e.vc), 8'(e.hs), 4'(e.vs), 4'(e.de)};
        chk(act == expv, "R4/R5/R6/R7/R8", "scoreboard {h,v,hs,vs,de}", act, expv);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk({hcount, vcount} == 24'd0, "R1", "counts", {hcount, vcount}, 0);
    chk({hsync, vsync, de, pclk_invert} == 4'd0, "R1", "outputs",
        {hsync, vsync, de, pclk_invert}, 0);
    rd(3'd0, d); chk(d == 32'd0, "R1", "ctrl reset", d, 0);
    rd(3'd1, d); chk(d == 32'd0, "R1", "htot reset", d, 0);

    // R2 field masking and layout
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk(d == 32'h0FFF_0FFF, "R2", "htot mask", d, 32'h0FFF_0FFF);
    wr(3'd1, (32'd9 << 16) | 32'd5);
    wr(3'd2, (32'd2 << 16) | 32'd7);
    wr(3'd3, (32'd5 << 16) | 32'd3);
    wr(3'd4, (32'd1 << 16) | 32'd4);
    rd(3'd2, d); chk(d == 32'h0002_0007, "R2", "hsync reg", d, 32'h0002_0007);
    rd(3'd4, d); chk(d == 32'h0001_0004, "R2", "vsync reg", d, 32'h0001_0004);

    // R10 and R11: plane set while stopped, reserved and status bits ignored
    wr(3'd0, 32'hFFFF_FFE2);
    rd(3'd0, d); chk(d == 32'h0000_0002, "R10/R11", "ctrl readback", d, 2);
    chk(de == 1'b0 && hcount == 12'd0, "R3", "stopped de/count", {de, hcount}, 0);

    // R3 inactive levels follow polarity while stopped
    wr(3'd0, 32'h0000_000E);
    chk({hsync, vsync} == 2'b11, "R3", "idle inverted syncs", {hsync, vsync}, 3);
    chk({hcount, vcount} == 24'd0, "R3", "idle counts", {hcount, vcount}, 0);

    // R4 R5 R6 R7: two frames plus some
    start_run(32'h0000_0003);
    push_run(130, 1'b0, 1'b0, 1'b1);
    wait (sb_q.size() == 0);

    // R8: inverted polarity frame
    start_run(32'h0000_000F);
    push_run(70, 1'b1, 1'b1, 1'b1);
    wait (sb_q.size() == 0);

    // R12 clock phase bit
    wr(3'd0, 32'h0000_0013);
    chk(pclk_invert == 1'b1, "R12", "pclk_invert set", pclk_invert, 1);
    wr(3'd0, 32'h0000_0003);
    chk(pclk_invert == 1'b0, "R12", "pclk_invert clear", pclk_invert, 0);

    // R9 plane off while running waits for the vsync line
    start_run(32'h0000_0003);
    wait_pos(2, 0);
    wr(3'd0, 32'h0000_0001);
    rd(3'd0, d); chk(d == 32'h0000_0003, "R9", "old plane readback", d, 3);
    wait_pos(0, 1);
    chk(de == 1'b1, "R9", "de before load", de, 1);
    wait_pos(0, 4);
    bus_addr = 3'd0; #1;
    chk(bus_rdata == 32'h0000_0103, "R9/R11", "ctrl at load pixel", bus_rdata, 32'h103);
    @(negedge clk); #1;
    chk(bus_rdata == 32'h0000_0101, "R9/R11", "ctrl after load", bus_rdata, 32'h101);
    wait_pos(0, 0);
    #1;
    chk(bus_rdata == 32'h0000_0001, "R11", "status low off vsync", bus_rdata, 1);
    chk(de == 1'b0, "R9", "de off next frame", de, 0);
    wait_pos(2, 1);
    chk(de == 1'b0, "R9", "de off line 1", de, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule